// File: doc/BRIEF.md
# Coprocessor Interface Register Unit

This unit is the bus-facing front end of a memory-mapped coprocessor. A host processor reaches it with ordinary read and write bus cycles. An access counts only when the function code marks the CPU address space and the upper address bits carry this unit's coprocessor number. Inside that window the unit holds a response word that the host reads, a command register and an operand register that the host writes, and a byte-wise assembly path that lets the host use an 8-, 16- or 32-bit data path.

To start an instruction, the host writes the command word and then reads the response. The response does one of three things. It can ask the host to send a given number of operand bytes. It can report that nothing more is needed. It can tell the host to wait because the previous instruction has not yet been taken by the execution side. Whether the host may run ahead is decided per instruction by the state of the unit. A command that arrives before the earlier one has left for the execution side is refused with the wait code. Once a command and all of its operand words are complete, the unit presents them to the execution side on a valid/ready handshake.

The sequencer has three states. IDLE accepts a command. IDLE goes to COLLECT when the command asks for operand words, and to HANDOFF when it asks for none. COLLECT stores operand words in order and goes to HANDOFF after the last one. HANDOFF holds the valid signal and returns to IDLE when the execution side signals ready. A command write in COLLECT or HANDOFF leaves the state as it is and sets the wait response.

Top module: `cpif_unit`

## Requirements
- R1: An access is decoded only when bus_cs_n is low, bus_fc equals 7, bus_addr[19:16] equals 4'h2, bus_addr[15:13] equals the COP_ID parameter and bus_addr[12:5] is zero. Any other access is never acknowledged and has no effect.
- R2: bus_dack_n goes low in the cycle after the access is decoded and stays low while bus_cs_n stays low. It is high again in the cycle after bus_cs_n rises. Each low period of bus_cs_n is one access.
- R3: bus_size codes are 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. Data is right-justified on bus_wdata/bus_rdata. The lowest byte address holds the most significant byte. A register write takes effect only when the access writes the register's last byte (0x0B for the command, 0x13 for the operand).
- R4: The 16-bit response is read at byte offsets 0x00 (high byte) and 0x01 (low byte). Every other offset reads as zero.
- R5: After reset the response is 16'h0802, ex_valid is low and bus_dack_n is high.
- R6: In IDLE, a command whose bits [11:10] give a word count N > 0 moves the unit to COLLECT and sets the response to 16'h1C00 | 4N. The low byte of that response is the operand length in bytes.
- R7: In IDLE, a command with N = 0 sets the response to 16'h0802 and moves straight to HANDOFF.
- R8: In COLLECT, each completed operand word at offset 0x10 is stored in arrival order. After the N-th word the response becomes 16'h0802 and the unit enters HANDOFF.
- R9: A command completed in COLLECT or HANDOFF sets the response to 16'h8900, is discarded, and leaves the pending instruction unchanged.
- R10: In HANDOFF, ex_valid stays high with ex_cmd, ex_nwords and ex_opnd stable until ex_ready. The unit is back in IDLE with ex_valid low in the next cycle. Operand word i appears at ex_opnd[32i+31:32i], and words at or above N read as zero.
- R11: Operand writes outside COLLECT change neither the response, the state nor the values presented to the execution side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Active-low access strobe |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_fc | input | 3 | Bus function code |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Transfer size code |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified |
| bus_dack_n | output | 1 | Active-low data acknowledge |
| ex_valid | output | 1 | Instruction ready for execution side |
| ex_ready | input | 1 | Execution side takes the instruction |
| ex_cmd | output | 16 | Accepted command word |
| ex_nwords | output | NW_W | Operand word count |
| ex_opnd | output | 32*(2**NW_W-1) | Operand words, word 0 lowest |

## Verification
A sequencer stuck in the wrong state shows at the ports at once. The response the host reads right after its command write has the wrong code: a busy unit that has wrongly gone back to IDLE answers with a transfer code or done instead of 16'h8900. A miscounted operand index shows up as ex_valid rising one word early or late, or as words in the wrong 32-bit slot of ex_opnd, within the same access that completes the word. A decode error shows within one cycle, either as a missing acknowledge or as an acknowledge to a foreign coprocessor number.

// File: rtl/cpif_pkg.sv
package cpif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HANDOFF
    } seq_state_t;

    localparam logic [15:0] RSP_DONE = 16'h0802;
    localparam logic [15:0] RSP_WAIT = 16'h8900;
    localparam logic [15:0] RSP_XFER = 16'h1C00;

    localparam int          OFF_W     = 5;
    localparam logic [5:0]  A_RESP_HI = 6'h00;
    localparam logic [5:0]  A_RESP_LO = 6'h01;
    localparam logic [5:0]  A_CMD_HI  = 6'h0A;
    localparam logic [5:0]  A_CMD_LO  = 6'h0B;
    localparam logic [5:0]  A_OPND    = 6'h10;

    localparam logic [2:0]  FC_CPU     = 3'd7;
    localparam logic [3:0]  SPACE_COP  = 4'h2;
    localparam int          CMD_NW_LSB = 10;
    localparam int          BUS_BYTES  = 4;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cpif_decode.sv
module cpif_decode
    import cpif_pkg::*;
#(
    parameter logic [2:0] COP_ID = 3'd1,
    parameter int         ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rw,
    input  logic [2:0]        bus_fc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [15:0]       resp_word,
    output logic              acc_stb,
    output logic              acc_wr,
    output logic [OFF_W-1:0]  acc_off,
    output logic [2:0]        acc_nbytes,
    output logic [31:0]       bus_rdata,
    output logic              bus_dack_n
);

    localparam int HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W-1:0] HI_PAT = HI_W'({SPACE_COP, COP_ID, 8'h00});

    logic        taken_q;
    logic        hit;
    logic [31:0] rd_nx;

    assign acc_nbytes = size_bytes(bus_size);
    assign acc_off    = bus_addr[OFF_W-1:0];
    assign acc_wr     = !bus_rw;
    assign hit        = !bus_cs_n && !taken_q && (bus_fc == FC_CPU)
                        && (bus_addr[ADDR_W-1:OFF_W] == HI_PAT);
    assign acc_stb    = hit;

    always_comb begin
        logic [5:0] a;
        logic [7:0] rb;
        rd_nx = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            a  = {1'b0, acc_off} + 6'(k);
            rb = (a == A_RESP_HI) ? resp_word[15:8] :
                 (a == A_RESP_LO) ? resp_word[7:0]  : 8'h00;
            if (k < int'(acc_nbytes))
                rd_nx = rd_nx | (32'(rb) << (8 * (int'(acc_nbytes) - 1 - k)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q    <= 1'b0;
            bus_dack_n <= 1'b1;
            bus_rdata  <= '0;
        end else if (bus_cs_n) begin
            taken_q    <= 1'b0;
            bus_dack_n <= 1'b1;
        end else if (hit) begin
            taken_q    <= 1'b1;
            bus_dack_n <= 1'b0;
            if (bus_rw)
                bus_rdata <= rd_nx;
        end
    end

    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !bus_dack_n);
    a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |=> bus_dack_n);
    a_r2_one_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
    a_r1_foreign_space: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dack_n && bus_fc != FC_CPU) |=> bus_dack_n);

endmodule

// File: rtl/cpif_merge.sv
module cpif_merge
    import cpif_pkg::*;
(
    input  logic             acc_stb,
    input  logic             acc_wr,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [2:0]       acc_nbytes,
    input  logic [31:0]      acc_wdata,
    input  logic [15:0]      cmd_cur,
    input  logic [31:0]      op_cur,
    output logic [15:0]      cmd_nx,
    output logic [31:0]      op_nx,
    output logic             cmd_done,
    output logic             op_done
);

    always_comb begin
        logic [5:0] a;
        logic [7:0] b;
        cmd_nx   = cmd_cur;
        op_nx    = op_cur;
        cmd_done = 1'b0;
        op_done  = 1'b0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            a = {1'b0, acc_off} + 6'(k);
            b = 8'(acc_wdata >> (8 * (int'(acc_nbytes) - 1 - k)));
            if (acc_stb && acc_wr && (k < int'(acc_nbytes))) begin
                if (a == A_CMD_HI)
                    cmd_nx[15:8] = b;
                if (a == A_CMD_LO) begin
                    cmd_nx[7:0] = b;
                    cmd_done    = 1'b1;
                end
                for (int j = 0; j < 4; j++) begin
                    if (a == A_OPND + 6'(j)) begin
                        op_nx[31-8*j -: 8] = b;
                        if (j == 3)
                            op_done = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cpif_seq.sv
module cpif_seq
    import cpif_pkg::*;
#(
    parameter int NW_W = 2,
    localparam int MAXW = (1 << NW_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_done,
    input  logic [15:0]        cmd_nx,
    input  logic               op_done,
    input  logic [31:0]        op_nx,
    output logic [15:0]        cmd_sh,
    output logic [31:0]        op_sh,
    output logic [15:0]        resp_word,
    output logic               ex_valid,
    input  logic               ex_ready,
    output logic [15:0]        ex_cmd,
    output logic [NW_W-1:0]    ex_nwords,
    output logic [MAXW*32-1:0] ex_opnd
);

    seq_state_t                st_q, st_nx;
    logic [15:0]               resp_q, resp_nx;
    logic [15:0]               cmd_q, cmd_q_nx;
    logic [NW_W-1:0]           nw_q, nw_nx;
    logic [NW_W-1:0]           cnt_q, cnt_nx;
    logic [MAXW-1:0][31:0]     opnd_q, opnd_nx;
    logic [NW_W-1:0]           n_new;

    assign n_new = cmd_nx[CMD_NW_LSB +: NW_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            resp_q <= RSP_DONE;
            cmd_q  <= '0;
            nw_q   <= '0;
            cnt_q  <= '0;
            opnd_q <= '0;
            cmd_sh <= '0;
            op_sh  <= '0;
        end else begin
            st_q   <= st_nx;
            resp_q <= resp_nx;
            cmd_q  <= cmd_q_nx;
            nw_q   <= nw_nx;
            cnt_q  <= cnt_nx;
            opnd_q <= opnd_nx;
            cmd_sh <= cmd_nx;
            op_sh  <= op_nx;
        end
    end

    always_comb begin
        st_nx    = st_q;
        resp_nx  = resp_q;
        cmd_q_nx = cmd_q;
        nw_nx    = nw_q;
        cnt_nx   = cnt_q;
        opnd_nx  = opnd_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_done) begin
                    cmd_q_nx = cmd_nx;
                    nw_nx    = n_new;
                    cnt_nx   = '0;
                    opnd_nx  = '0;
                    if (n_new == '0) begin
                        resp_nx = RSP_DONE;
                        st_nx   = ST_HANDOFF;
                    end else begin
                        resp_nx = RSP_XFER | (16'(n_new) << 2);
                        st_nx   = ST_COLLECT;
                    end
                end
            end
            ST_COLLECT: begin
                if (cmd_done) begin
                    resp_nx = RSP_WAIT;
                end else if (op_done) begin
                    for (int i = 0; i < MAXW; i++)
                        if (cnt_q == NW_W'(i))
                            opnd_nx[i] = op_nx;
                    if (cnt_q == nw_q - NW_W'(1)) begin
                        resp_nx = RSP_DONE;
                        st_nx   = ST_HANDOFF;
                    end else begin
                        cnt_nx = cnt_q + NW_W'(1);
                    end
                end
            end
            ST_HANDOFF: begin
                if (cmd_done)
                    resp_nx = RSP_WAIT;
                if (ex_ready)
                    st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        resp_word = resp_q;
        ex_valid  = (st_q == ST_HANDOFF);
        ex_cmd    = cmd_q;
        ex_nwords = nw_q;
    end

    for (genvar g = 0; g < MAXW; g++) begin : g_opnd
        assign ex_opnd[32*g +: 32] = opnd_q[g];
    end

    a_r9_wait_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && st_q != ST_IDLE) |=> (resp_word == RSP_WAIT));
    a_r9_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && st_q != ST_IDLE) |=> $stable(ex_cmd));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_ready) |=> (ex_valid && $stable(ex_cmd) && $stable(ex_opnd)));
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ready) |=> !ex_valid);
    a_r8_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COLLECT) |-> (cnt_q < nw_q));
    a_r6_collect_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cmd_done && n_new != '0) |=> (st_q == ST_COLLECT));
    a_r11_idle_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && op_done && !cmd_done) |=> ($stable(resp_word) && !ex_valid));

endmodule

// File: rtl/cpif_unit.sv
module cpif_unit
    import cpif_pkg::*;
#(
    parameter logic [2:0] COP_ID = 3'd1,
    parameter int         ADDR_W = 20,
    parameter int         NW_W   = 2,
    localparam int        MAXW   = (1 << NW_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cs_n,
    input  logic               bus_rw,
    input  logic [2:0]         bus_fc,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_dack_n,
    output logic               ex_valid,
    input  logic               ex_ready,
    output logic [15:0]        ex_cmd,
    output logic [NW_W-1:0]    ex_nwords,
    output logic [MAXW*32-1:0] ex_opnd
);

    logic             acc_stb, acc_wr;
    logic [OFF_W-1:0] acc_off;
    logic [2:0]       acc_nbytes;
    logic [15:0]      resp_word, cmd_sh, cmd_nx;
    logic [31:0]      op_sh, op_nx;
    logic             cmd_done, op_done;

    cpif_decode #(.COP_ID(COP_ID), .ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
        .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_size(bus_size),
        .resp_word(resp_word), .acc_stb(acc_stb), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_nbytes(acc_nbytes),
        .bus_rdata(bus_rdata), .bus_dack_n(bus_dack_n)
    );

    cpif_merge u_merge (
        .acc_stb(acc_stb), .acc_wr(acc_wr), .acc_off(acc_off),
        .acc_nbytes(acc_nbytes), .acc_wdata(bus_wdata),
        .cmd_cur(cmd_sh), .op_cur(op_sh), .cmd_nx(cmd_nx), .op_nx(op_nx),
        .cmd_done(cmd_done), .op_done(op_done)
    );

    cpif_seq #(.NW_W(NW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_nx(cmd_nx),
        .op_done(op_done), .op_nx(op_nx), .cmd_sh(cmd_sh), .op_sh(op_sh),
        .resp_word(resp_word), .ex_valid(ex_valid), .ex_ready(ex_ready),
        .ex_cmd(ex_cmd), .ex_nwords(ex_nwords), .ex_opnd(ex_opnd)
    );

endmodule

// File: tb/cpif_unit_tb.sv
module cpif_unit_tb;

    localparam logic [2:0] ID = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_cs_n, bus_rw;
    logic [2:0]  bus_fc;
    logic [19:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_dack_n, ex_valid, ex_ready;
    logic [15:0] ex_cmd;
    logic [1:0]  ex_nwords;
    logic [95:0] ex_opnd;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cpif_unit #(.COP_ID(ID), .ADDR_W(20), .NW_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
        .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_dack_n(bus_dack_n),
        .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_cmd(ex_cmd),
        .ex_nwords(ex_nwords), .ex_opnd(ex_opnd)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input int nb);
        return (nb == 1) ? 2'd0 : (nb == 2) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [15:0] xfer_code(input int n);
        return 16'h1C00 | 16'(4 * n);
    endfunction

    task automatic acc(input logic [2:0] fc, input logic [2:0] id, input bit rd,
                       input int nb, input logic [4:0] off, input logic [31:0] wd,
                       output logic [31:0] rdv, output bit ack);
        @(negedge clk);
        bus_cs_n  = 1'b0;
        bus_fc    = fc;
        bus_addr  = {4'h2, id, 8'h00, off};
        bus_rw    = rd;
        bus_size  = code_of(nb);
        bus_wdata = wd;
        @(negedge clk);
        ack = !bus_dack_n;
        rdv = bus_rdata;
        if (!ack) begin
            repeat (3) begin
                @(negedge clk);
                if (!bus_dack_n) ack = 1'b1;
            end
        end
        bus_cs_n = 1'b1;
        @(negedge clk);
        chk(bus_dack_n == 1'b1, "R2 release", 96'(bus_dack_n), 96'(1));
    endtask

    task automatic host(input bit rd, input int nb, input logic [4:0] off,
                        input logic [31:0] wd, output logic [31:0] rdv);
        bit ack;
        acc(3'd7, ID, rd, nb, off, wd, rdv, ack);
        chk(ack, "R2 ack", 96'(ack), 96'(1));
    endtask

    task automatic wr_reg(input logic [4:0] off, input int total, input logic [31:0] val, input int nb);
        logic [31:0] dummy;
        for (int j = 0; j < total / nb; j++) begin
            logic [31:0] piece;
            piece = val >> (8 * (total - nb * (j + 1)));
            if (nb == 1) piece = piece & 32'hFF;
            if (nb == 2) piece = piece & 32'hFFFF;
            host(1'b0, nb, off + 5'(j * nb), piece, dummy);
        end
    endtask

    task automatic rd_resp(input int mode, output logic [15:0] r);
        logic [31:0] a, b;
        if (mode == 0) begin
            host(1'b1, 1, 5'h00, 32'h0, a);
            host(1'b1, 1, 5'h01, 32'h0, b);
            r = {a[7:0], b[7:0]};
        end else if (mode == 1) begin
            host(1'b1, 2, 5'h00, 32'h0, a);
            r = a[15:0];
        end else begin
            host(1'b1, 4, 5'h00, 32'h0, a);
            r = a[31:16];
            chk(a[15:0] == 16'h0, "R4 long low half", 96'(a[15:0]), 96'(0));
        end
    endtask

    task automatic drain();
        @(negedge clk);
        ex_ready = 1'b1;
        @(negedge clk);
        ex_ready = 1'b0;
        chk(!ex_valid, "R10 release", 96'(ex_valid), 96'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, mresp, cmd;
        logic [31:0] rv;
        logic [95:0] exp_op;
        bit ack;
        int n, mode;
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; bus_cs_n = 1'b1; bus_rw = 1'b1; bus_fc = 3'd0;
        bus_addr = '0; bus_size = 2'd0; bus_wdata = '0; ex_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        chk(bus_dack_n == 1'b1, "R5 dack idle", 96'(bus_dack_n), 96'(1));
        chk(!ex_valid, "R5 valid low", 96'(ex_valid), 96'(0));
        rd_resp(1, r);
        chk(r == 16'h0802, "R5 response", 96'(r), 96'h0802);
        // R4 byte read and zero offsets
        host(1'b1, 1, 5'h01, 32'h0, rv);
        chk(rv == 32'h02, "R4 low byte", 96'(rv), 96'h02);
        host(1'b1, 2, 5'h0A, 32'h0, rv);
        chk(rv == 32'h0, "R4 command reads zero", 96'(rv), 96'h0);
        host(1'b1, 4, 5'h10, 32'h0, rv);
        chk(rv == 32'h0, "R4 operand reads zero", 96'(rv), 96'h0);

        // R3 command assembled byte-wise, takes effect on last byte
        host(1'b0, 1, 5'h0A, 32'hA0, rv);
        chk(!ex_valid, "R3 partial command", 96'(ex_valid), 96'(0));
        host(1'b0, 1, 5'h0B, 32'h5C, rv);
        chk(ex_valid, "R3 command complete", 96'(ex_valid), 96'(1));
        chk(ex_cmd == 16'hA05C, "R3 byte order", 96'(ex_cmd), 96'hA05C);
        drain();
        mresp = 16'h0802;

        // R11 operand write in IDLE
        wr_reg(5'h10, 4, 32'hDEAD_BEEF, 4);
        chk(!ex_valid, "R11 idle operand valid", 96'(ex_valid), 96'(0));
        rd_resp(2, r);
        chk(r == mresp, "R11 idle operand response", 96'(r), 96'(mresp));

        // R1 foreign accesses
        acc(3'd5, ID, 1'b0, 2, 5'h0A, 32'h0000_0000, rv, ack);
        chk(!ack, "R1 wrong function code", 96'(ack), 96'(0));
        acc(3'd7, ID ^ 3'd2, 1'b0, 2, 5'h0A, 32'h0000_0000, rv, ack);
        chk(!ack, "R1 wrong id", 96'(ack), 96'(0));
        chk(!ex_valid, "R1 no effect", 96'(ex_valid), 96'(0));

        for (int it = 0; it < 60; it++) begin
            bit busy_hit;
            n = int'($urandom % 4);
            cmd = 16'($urandom);
            cmd[11:10] = 2'(n);
            wr_reg(5'h0A, 2, 32'(cmd), ($urandom % 2) ? 2 : 1);
            mode = int'($urandom % 3);
            rd_resp(mode, r);
            if (n == 0) begin
                chk(r == 16'h0802, "R7 null response", 96'(r), 96'h0802);
                chk(ex_valid, "R7 direct handoff", 96'(ex_valid), 96'(1));
            end else begin
                chk(r == xfer_code(n), "R6 transfer response", 96'(r), 96'(xfer_code(n)));
                chk(!ex_valid, "R6 waits for operands", 96'(ex_valid), 96'(0));
            end
            busy_hit = ($urandom % 3) == 0;
            if (busy_hit) begin
                wr_reg(5'h0A, 2, $urandom, 2);
                rd_resp(1, r);
                chk(r == 16'h8900, "R9 wait response", 96'(r), 96'h8900);
                chk(ex_valid == (n == 0), "R9 state kept", 96'(ex_valid), 96'(n == 0));
            end
            exp_op = '0;
            for (int w = 0; w < n; w++) begin
                logic [31:0] v;
                int sel;
                v = $urandom;
                sel = int'($urandom % 3);
                exp_op[32*w +: 32] = v;
                wr_reg(5'h10, 4, v, (sel == 0) ? 1 : (sel == 1) ? 2 : 4);
                if (w < n - 1)
                    chk(!ex_valid, "R8 early valid", 96'(ex_valid), 96'(0));
            end
            mresp = (n == 0 && busy_hit) ? 16'h8900 : 16'h0802;
            chk(ex_valid, "R8 handoff after last word", 96'(ex_valid), 96'(1));
            rd_resp(int'($urandom % 3), r);
            chk(r == mresp, "R8 done response", 96'(r), 96'(mresp));
            chk(ex_cmd == cmd, "R10 command", 96'(ex_cmd), 96'(cmd));
            chk(ex_nwords == 2'(n), "R10 word count", 96'(ex_nwords), 96'(n));
            chk(ex_opnd == exp_op, "R10 operands", ex_opnd, exp_op);
            if (($urandom % 3) == 0) begin
                wr_reg(5'h10, 4, $urandom, 4);
                chk(ex_opnd == exp_op, "R11 handoff operand", ex_opnd, exp_op);
                rd_resp(1, r);
                chk(r == mresp, "R11 handoff response", 96'(r), 96'(mresp));
            end
            repeat (int'($urandom % 4)) @(negedge clk);
            chk(ex_valid && ex_cmd == cmd, "R10 hold", 96'(ex_cmd), 96'(cmd));
            drain();
            if (($urandom % 4) == 0) begin
                acc(3'd7, ID ^ 3'd1, 1'b0, 2, 5'h0A, 32'h0, rv, ack);
                chk(!ack, "R1 foreign id", 96'(ack), 96'(0));
                chk(!ex_valid, "R1 foreign no effect", 96'(ex_valid), 96'(0));
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule